// File: doc/BRIEF.md
# Stack and Interrupt Vector Sequencer

This block carries out, one bus cycle at a time, the control transfers of an 8-bit processor that go through the stack or through a vector. The transfers are the software break, subroutine call and return, return from interrupt, and push or pull of the accumulator or the status byte. The same engine also serves a maskable interrupt line, an edge-triggered non-maskable interrupt line and a reset-sequence line. The stack lives in page 1 of a 16-bit address space. An 8-bit pointer addresses it and counts downward, which gives an effective 9-bit pointer whose top bit is always 1. The pointer resets to FFh, so the first push goes to 01FFh. Vectors sit at the top of memory and are stored low byte first. A return address is pushed high byte first, so its low byte sits at the lower stack address.

The surrounding core presents a transfer as a valid/ready stream: `req_valid` with `req_op` and the current PC, A and P on `pc_in`, `a_in` and `p_in`. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid`, `req_op` and the operands stable until that edge. `req_ready` is low while a transfer is running and in any idle cycle in which a reset, an NMI or an unmasked IRQ is taken instead. The interrupt and reset lines are plain levels and are not part of the handshake. The block drives the address bus, write data and a read strobe, and reads `bus_rdata` in the same cycle as the address. When the last bus cycle completes it raises `done` for one cycle. At that point `pc_out`, `a_out`, `p_out` and `cycles` hold the outcome. `sp_out` always shows the live stack pointer.

Top module: `stkvec_seq`

## Requirements
- R1: A push writes to address {01h, SP} and then decrements SP. A pull increments SP and then reads {01h, SP}. Every bus write lands in page 01h. SP is FFh after `rst_n`.
- R2: Break (req_op 0) takes 7 bus cycles. It pushes PC+2 high byte then low byte, then pushes P with bit 4 set. It loads the PC from FFFEh (low) and FFFFh (high), and returns P with bit 2 set. SP drops by 3.
- R3: While idle, a high `irq_req` with `p_in` bit 2 clear starts a 7-cycle sequence. The sequence pushes the PC unchanged (high byte then low byte), then P with bit 4 clear, and vectors through FFFEh/FFFFh with P bit 2 set. With `p_in` bit 2 set the line is ignored: no bus write, no `done`, SP unchanged and `req_ready` stays high.
- R4: A rising edge on `nmi_req` is latched and taken at the next idle edge whatever the value of P bit 2. The sequence is the same as R3, with the vector at FFFAh/FFFBh.
- R5: While idle, a high `rst_req` starts a 7-cycle sequence that performs no bus write and leaves SP unchanged. It loads the PC from FFFCh/FFFDh and returns P with bit 2 set.
- R6: A subroutine call (req_op 1) takes 6 cycles. It reads the target low byte at PC+1 and the high byte at PC+2, pushes PC+2 high byte first, and returns the target as the new PC.
- R7: A subroutine return (req_op 2) takes 6 cycles. It pulls the low byte and then the high byte, and returns the pulled address plus 1.
- R8: A return from interrupt (req_op 3) takes 6 cycles. It pulls P, then the PC low byte, then the high byte. Every bit of the returned P comes from the pulled byte, and the returned PC is the pulled address.
- R9: Push A (req_op 4) and push P (req_op 5) take 3 cycles each. The pushed status byte has bit 4 set, and the returned P equals `p_in`.
- R10: Pull A (req_op 6) and pull P (req_op 7) take 4 cycles each. Pull A returns the byte as A and sets P bit 7 to its bit 7 and P bit 1 to (byte == 0). All other P bits are kept. Pull P replaces P with the byte.
- R11: The first bus cycle of an accepted request follows its accept edge directly. `done` is high for exactly one cycle, right after the last bus cycle, with `cycles` equal to that transfer's cycle count. `req_ready` is low whenever a transfer is in progress.
- R12: When several sources compete in an idle cycle, the order of priority is `rst_req`, then a latched NMI, then an unmasked IRQ, then the request stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 3 | Transfer code (0 break, 1 call, 2 return, 3 interrupt return, 4 push A, 5 push P, 6 pull A, 7 pull P) |
| pc_in | input | 16 | Current program counter |
| a_in | input | 8 | Current accumulator |
| p_in | input | 8 | Current status byte (bit 2 masks IRQ) |
| irq_req | input | 1 | Maskable interrupt level |
| nmi_req | input | 1 | Non-maskable interrupt, rising-edge sensitive |
| rst_req | input | 1 | Reset-sequence request level |
| bus_addr | output | 16 | Address bus |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the address cycle |
| bus_rd | output | 1 | 1 = read cycle, 0 = write cycle |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| a_out | output | 8 | Resulting accumulator |
| p_out | output | 8 | Resulting status byte |
| sp_out | output | 8 | Live stack pointer (low byte, page 01h implied) |
| cycles | output | 3 | Bus cycle count of the finished transfer |

## Verification
A request accepted at clock edge n has its bus cycles in the intervals after edges n through n+N-1. `done` and the results appear after edge n+N, where N is 3, 4, 6 or 7 depending on the transfer. A latched NMI adds one more edge, because the edge that detects it comes before the edge that accepts it. The bench drives inputs on falling edges and counts falling edges from the accept edge until `done` is seen, so it checks the measured count against N as well as the `cycles` port. Results, SP and the contents of the bench's stack memory are read only at that falling edge.

// File: rtl/svseq_pkg.sv
`timescale 1ns/1ps
package svseq_pkg;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int SW = 3;
  localparam int OPW = 3;
  localparam logic [DW-1:0] STACK_PAGE = 8'h01;
  localparam logic [AW-1:0] VEC_NMI = 16'hFFFA;
  localparam logic [AW-1:0] VEC_RST = 16'hFFFC;
  localparam logic [AW-1:0] VEC_IRQ = 16'hFFFE;
  localparam int BIT_N = 7;
  localparam int BIT_B = 4;
  localparam int BIT_I = 2;
  localparam int BIT_Z = 1;

  typedef enum logic [3:0] {
    K_BRK = 4'd0, K_JSR = 4'd1, K_RTS = 4'd2, K_RTI = 4'd3,
    K_PHA = 4'd4, K_PHP = 4'd5, K_PLA = 4'd6, K_PLP = 4'd7,
    K_IRQ = 4'd8, K_NMI = 4'd9, K_RST = 4'd10
  } kind_e;

  typedef enum logic [3:0] {
    S_FETCH0, S_FETCH1, S_FETCH2, S_STKRD,
    S_PUSH_PCH, S_PUSH_PCL, S_PUSH_P, S_PUSH_A,
    S_PULL_P, S_PULL_A, S_PULL_PCL, S_PULL_PCH,
    S_VEC_LO, S_VEC_HI, S_RET_RD
  } act_e;
endpackage

// File: rtl/svseq_steps.sv
`timescale 1ns/1ps
module svseq_steps
  import svseq_pkg::*;
(
  input  kind_e           kind,
  input  logic [SW-1:0]   step,
  output act_e            act,
  output logic            last
);
  always_comb begin
    act  = S_STKRD;
    last = 1'b0;
    if (step == SW'(0)) begin
      act = S_FETCH0;
    end else if (step == SW'(1)) begin
      act = S_FETCH1;
    end else begin
      case (kind)
        K_BRK, K_IRQ, K_NMI: begin
          case (step)
            SW'(2): act = S_PUSH_PCH;
            SW'(3): act = S_PUSH_PCL;
            SW'(4): act = S_PUSH_P;
            SW'(5): act = S_VEC_LO;
            default: begin act = S_VEC_HI; last = 1'b1; end
          endcase
        end
        K_RST: begin
          case (step)
            SW'(5): act = S_VEC_LO;
            SW'(6): begin act = S_VEC_HI; last = 1'b1; end
            default: act = S_STKRD;
          endcase
        end
        K_JSR: begin
          case (step)
            SW'(2): act = S_STKRD;
            SW'(3): act = S_PUSH_PCH;
            SW'(4): act = S_PUSH_PCL;
            default: begin act = S_FETCH2; last = 1'b1; end
          endcase
        end
        K_RTS: begin
          case (step)
            SW'(2): act = S_STKRD;
            SW'(3): act = S_PULL_PCL;
            SW'(4): act = S_PULL_PCH;
            default: begin act = S_RET_RD; last = 1'b1; end
          endcase
        end
        K_RTI: begin
          case (step)
            SW'(2): act = S_STKRD;
            SW'(3): act = S_PULL_P;
            SW'(4): act = S_PULL_PCL;
            default: begin act = S_PULL_PCH; last = 1'b1; end
          endcase
        end
        K_PHA: begin act = S_PUSH_A; last = 1'b1; end
        K_PHP: begin act = S_PUSH_P; last = 1'b1; end
        K_PLA: begin
          if (step == SW'(2)) act = S_STKRD;
          else begin act = S_PULL_A; last = 1'b1; end
        end
        default: begin
          if (step == SW'(2)) act = S_STKRD;
          else begin act = S_PULL_P; last = 1'b1; end
        end
      endcase
    end
  end
endmodule

// File: rtl/svseq_sp.sv
`timescale 1ns/1ps
module svseq_sp
  import svseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pull,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] sp_up
);
  assign sp_up = sp + DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp <= '1;
    else if (push) sp <= sp - DW'(1);
    else if (pull) sp <= sp_up;
  end

  // R1: a push leaves the pointer one lower, a pull one higher
  a_r1_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp == $past(sp) - DW'(1)));
  a_r1_pull_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pull |=> (sp == $past(sp) + DW'(1)));
  a_r1_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pull));
endmodule

// File: rtl/svseq_arb.sv
`timescale 1ns/1ps
module svseq_arb
  import svseq_pkg::*;
(
  input  logic           idle,
  input  logic           rst_req,
  input  logic           nmi_pend,
  input  logic           irq_live,
  input  logic           req_valid,
  input  logic [OPW-1:0] req_op,
  output logic           take,
  output kind_e          kind,
  output logic           req_ready
);
  assign req_ready = idle && !rst_req && !nmi_pend && !irq_live;

  always_comb begin
    take = 1'b0;
    kind = K_BRK;
    if (idle) begin
      if (rst_req) begin
        take = 1'b1; kind = K_RST;
      end else if (nmi_pend) begin
        take = 1'b1; kind = K_NMI;
      end else if (irq_live) begin
        take = 1'b1; kind = K_IRQ;
      end else if (req_valid) begin
        take = 1'b1; kind = kind_e'({1'b0, req_op});
      end
    end
  end
endmodule

// File: rtl/stkvec_seq.sv
`timescale 1ns/1ps
module stkvec_seq
  import svseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [OPW-1:0] req_op,
  input  logic [AW-1:0]  pc_in,
  input  logic [DW-1:0]  a_in,
  input  logic [DW-1:0]  p_in,
  input  logic           irq_req,
  input  logic           nmi_req,
  input  logic           rst_req,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  output logic           bus_rd,
  output logic           done,
  output logic [AW-1:0]  pc_out,
  output logic [DW-1:0]  a_out,
  output logic [DW-1:0]  p_out,
  output logic [DW-1:0]  sp_out,
  output logic [SW-1:0]  cycles
);
  logic          busy, done_q, nmi_q, nmi_pend, take, last, push, pull, hw_int;
  logic [SW-1:0] step, cyc_q;
  kind_e         kind, kind_q;
  act_e          act;
  logic [AW-1:0] pc_w, ret_pc, wrd, vec_base;
  logic [DW-1:0] a_w, p_w, sp, sp_up, p_push;

  wire irq_live = irq_req && !p_in[BIT_I];

  svseq_arb u_arb (
    .idle(!busy), .rst_req(rst_req), .nmi_pend(nmi_pend), .irq_live(irq_live),
    .req_valid(req_valid), .req_op(req_op), .take(take), .kind(kind),
    .req_ready(req_ready)
  );

  svseq_steps u_steps (.kind(kind_q), .step(step), .act(act), .last(last));

  assign push = busy && (act == S_PUSH_PCH || act == S_PUSH_PCL ||
                         act == S_PUSH_P   || act == S_PUSH_A);
  assign pull = busy && (act == S_PULL_P   || act == S_PULL_A ||
                         act == S_PULL_PCL || act == S_PULL_PCH);

  svseq_sp u_sp (.clk(clk), .rst_n(rst_n), .push(push), .pull(pull),
                 .sp(sp), .sp_up(sp_up));

  assign hw_int = (kind_q == K_IRQ) || (kind_q == K_NMI);

  always_comb begin
    p_push        = p_w;
    p_push[BIT_B] = !hw_int;
    case (kind_q)
      K_NMI:   vec_base = VEC_NMI;
      K_RST:   vec_base = VEC_RST;
      default: vec_base = VEC_IRQ;
    endcase
  end

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    bus_rd    = 1'b1;
    if (busy) begin
      case (act)
        S_FETCH0:   bus_addr = pc_w;
        S_FETCH1:   bus_addr = pc_w + AW'(1);
        S_FETCH2:   bus_addr = pc_w + AW'(2);
        S_STKRD:    bus_addr = {STACK_PAGE, sp};
        S_PUSH_PCH: begin bus_addr = {STACK_PAGE, sp}; bus_rd = 1'b0; bus_wdata = ret_pc[AW-1:DW]; end
        S_PUSH_PCL: begin bus_addr = {STACK_PAGE, sp}; bus_rd = 1'b0; bus_wdata = ret_pc[DW-1:0]; end
        S_PUSH_P:   begin bus_addr = {STACK_PAGE, sp}; bus_rd = 1'b0; bus_wdata = p_push; end
        S_PUSH_A:   begin bus_addr = {STACK_PAGE, sp}; bus_rd = 1'b0; bus_wdata = a_w; end
        S_PULL_P, S_PULL_A, S_PULL_PCL, S_PULL_PCH: bus_addr = {STACK_PAGE, sp_up};
        S_VEC_LO:   bus_addr = vec_base;
        S_VEC_HI:   bus_addr = vec_base | AW'(1);
        S_RET_RD:   bus_addr = wrd;
        default:    bus_addr = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; step <= '0; kind_q <= K_BRK; done_q <= 1'b0; cyc_q <= '0;
      nmi_q <= 1'b0; nmi_pend <= 1'b0;
      pc_w <= '0; a_w <= '0; p_w <= '0; ret_pc <= '0; wrd <= '0;
    end else begin
      done_q <= 1'b0;
      nmi_q  <= nmi_req;
      if (nmi_req && !nmi_q)            nmi_pend <= 1'b1;
      else if (take && kind == K_NMI)   nmi_pend <= 1'b0;

      if (take) begin
        busy   <= 1'b1;
        step   <= '0;
        kind_q <= kind;
        pc_w   <= pc_in;
        a_w    <= a_in;
        p_w    <= p_in;
        ret_pc <= pc_in + ((kind == K_BRK || kind == K_JSR) ? AW'(2) : AW'(0));
      end else if (busy) begin
        step <= step + SW'(1);
        case (act)
          S_FETCH1:   wrd[DW-1:0] <= bus_rdata;
          S_FETCH2:   pc_w <= {bus_rdata, wrd[DW-1:0]};
          S_PULL_P:   p_w <= bus_rdata;
          S_PULL_A: begin
            a_w        <= bus_rdata;
            p_w[BIT_N] <= bus_rdata[DW-1];
            p_w[BIT_Z] <= (bus_rdata == '0);
          end
          S_PULL_PCL: wrd[DW-1:0] <= bus_rdata;
          S_PULL_PCH: begin
            wrd[AW-1:DW] <= bus_rdata;
            if (kind_q == K_RTI) pc_w <= {bus_rdata, wrd[DW-1:0]};
          end
          S_RET_RD:   pc_w <= wrd + AW'(1);
          S_VEC_LO: begin
            wrd[DW-1:0] <= bus_rdata;
            p_w[BIT_I]  <= 1'b1;
          end
          S_VEC_HI:   pc_w <= {bus_rdata, wrd[DW-1:0]};
          default: ;
        endcase
        if (last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
          cyc_q  <= step + SW'(1);
        end
      end
    end
  end

  assign done   = done_q;
  assign pc_out = pc_w;
  assign a_out  = a_w;
  assign p_out  = p_w;
  assign sp_out = sp;
  assign cycles = cyc_q;

  // R1: writes never leave the stack page
  a_r1_write_in_stack: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_addr[AW-1:DW] == STACK_PAGE));
  // R2: vector fetches stay in the top eight bytes of memory
  a_r2_vec_top: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (act == S_VEC_LO || act == S_VEC_HI)) |-> (bus_addr[AW-1:3] == '1));
  // R3: a masked IRQ with nothing else pending starts nothing
  a_r3_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irq_req && p_in[BIT_I] && !rst_req && !nmi_pend && !req_valid) |=> !busy);
  // R5: the reset sequence never writes
  a_r5_reset_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == K_RST) |-> bus_rd);
  // R11: completion is a single-cycle pulse, ready only while idle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
endmodule

// File: tb/test_stkvec_seq.sv
`timescale 1ns/1ps
module test_stkvec_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  a_in = '0, p_in = '0;
  logic        irq_req = 1'b0, nmi_req = 1'b0, rst_req = 1'b0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_rd, done;
  logic [15:0] pc_out;
  logic [7:0]  a_out, p_out, sp_out;
  logic [2:0]  cycles;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  stkvec_seq i_stkvec_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .pc_in(pc_in), .a_in(a_in), .p_in(p_in),
    .irq_req(irq_req), .nmi_req(nmi_req), .rst_req(rst_req),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .done(done), .pc_out(pc_out), .a_out(a_out),
    .p_out(p_out), .sp_out(sp_out), .cycles(cycles)
  );

  // sparse memory: pages 01h, 80h, FFh, everything else folds onto one page
  logic [7:0] mem [0:1023];
  function automatic logic [9:0] midx(input logic [15:0] a);
    logic [1:0] s;
    case (a[15:8])
      8'h01:   s = 2'd1;
      8'h80:   s = 2'd2;
      8'hFF:   s = 2'd3;
      default: s = 2'd0;
    endcase
    return {s, a[7:0]};
  endfunction

  always_comb bus_rdata = mem[midx(bus_addr)];
  always @(posedge clk) begin
    if (rst_n && !bus_rd) begin
      mem[midx(bus_addr)] <= bus_wdata;
      wr_cnt = wr_cnt + 1;
    end
  end

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] pc;
    logic [7:0]  a, p;
    logic [15:0] epc;
    logic [7:0]  ea, ep, esp;
    logic [3:0]  ecyc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{3'd1, 16'h8000, 8'h11, 8'h00, 16'hABCD, 8'h11, 8'h00, 8'hFD, 4'd6}, // R6 call
    '{3'd4, 16'hABCD, 8'h5A, 8'h00, 16'hABCD, 8'h5A, 8'h00, 8'hFC, 4'd3}, // R9 push A
    '{3'd5, 16'hABCD, 8'h5A, 8'hC3, 16'hABCD, 8'h5A, 8'hC3, 8'hFB, 4'd3}, // R9 push P
    '{3'd6, 16'hABCD, 8'h00, 8'h00, 16'hABCD, 8'hD3, 8'h80, 8'hFC, 4'd4}, // R10 pull A, negative
    '{3'd7, 16'hABCD, 8'hD3, 8'h80, 16'hABCD, 8'hD3, 8'h5A, 8'hFD, 4'd4}, // R10 pull P
    '{3'd2, 16'hABCD, 8'hD3, 8'h5A, 16'h8003, 8'hD3, 8'h5A, 8'hFF, 4'd6}, // R7 return
    '{3'd0, 16'h8010, 8'h01, 8'h00, 16'h5678, 8'h01, 8'h04, 8'hFC, 4'd7}, // R2 break
    '{3'd3, 16'h5678, 8'h01, 8'h04, 16'h8012, 8'h01, 8'h10, 8'hFF, 4'd6}, // R8 interrupt return
    '{3'd4, 16'h8012, 8'h00, 8'h00, 16'h8012, 8'h00, 8'h00, 8'hFE, 4'd3}, // R9 push zero
    '{3'd6, 16'h8012, 8'h77, 8'h80, 16'h8012, 8'h00, 8'h02, 8'hFF, 4'd4}  // R10 pull A, zero
  };

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4, 3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output int n);
    n = -1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (done) begin n = k - 1; break; end
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] pc,
                       input logic [7:0] a, input logic [7:0] p);
    @(negedge clk);
    req_op = op; pc_in = pc; a_in = a; p_in = p; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    chk("R11", "ready while busy", {31'd0, req_ready}, 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: got hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int n, w0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem[midx(16'hFFFA)] = 8'h00; mem[midx(16'hFFFB)] = 8'h90;
    mem[midx(16'hFFFC)] = 8'h34; mem[midx(16'hFFFD)] = 8'h12;
    mem[midx(16'hFFFE)] = 8'h78; mem[midx(16'hFFFF)] = 8'h56;
    mem[midx(16'h8001)] = 8'hCD; mem[midx(16'h8002)] = 8'hAB;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state (R1, R11)
    chk("R1", "sp after reset", {24'd0, sp_out}, 32'hFF);
    chk("R11", "done after reset", {31'd0, done}, 32'd0);
    chk("R11", "ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1", "no write after reset", {31'd0, bus_rd}, 32'd1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].op, TBL[i].pc, TBL[i].a, TBL[i].p);
      wait_done(n);
      chk(req_of(TBL[i].op), "bus cycles seen", n, {28'd0, TBL[i].ecyc});
      chk(req_of(TBL[i].op), "cycles port", {29'd0, cycles}, {28'd0, TBL[i].ecyc});
      chk(req_of(TBL[i].op), "pc", {16'd0, pc_out}, {16'd0, TBL[i].epc});
      chk(req_of(TBL[i].op), "a", {24'd0, a_out}, {24'd0, TBL[i].ea});
      chk(req_of(TBL[i].op), "p", {24'd0, p_out}, {24'd0, TBL[i].ep});
      chk("R1", "sp", {24'd0, sp_out}, {24'd0, TBL[i].esp});
    end
    // stack contents left by break and push P
    chk("R2", "break pushed PCL", {24'd0, mem[midx(16'h01FE)]}, 32'h12);
    chk("R2", "break pushed P with B", {24'd0, mem[midx(16'h01FD)]}, 32'h10);
    chk("R9", "push P has B", {24'd0, mem[midx(16'h01FC)]}, 32'hD3);

    // R6 byte order of the return address
    issue(3'd1, 16'h8000, 8'h00, 8'h00);
    wait_done(n);
    chk("R6", "high byte at 01FF", {24'd0, mem[midx(16'h01FF)]}, 32'h80);
    chk("R6", "low byte at 01FE", {24'd0, mem[midx(16'h01FE)]}, 32'h02);
    issue(3'd2, 16'hABCD, 8'h00, 8'h00);
    wait_done(n);
    chk("R7", "return pc", {16'd0, pc_out}, 32'h8003);
    chk("R1", "sp restored", {24'd0, sp_out}, 32'hFF);

    // R3 masked IRQ is ignored
    @(negedge clk);
    w0 = wr_cnt; p_in = 8'h04; irq_req = 1'b1;
    n = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) n++;
    end
    chk("R3", "masked irq done pulses", n, 32'd0);
    chk("R3", "masked irq writes", wr_cnt - w0, 32'd0);
    chk("R3", "masked irq sp", {24'd0, sp_out}, 32'hFF);
    chk("R3", "masked irq ready", {31'd0, req_ready}, 32'd1);
    irq_req = 1'b0;

    // R3 IRQ taken
    @(negedge clk);
    p_in = 8'h01; pc_in = 16'h8020; irq_req = 1'b1;
    @(posedge clk);
    #1 irq_req = 1'b0;
    wait_done(n);
    chk("R3", "irq cycles", n, 32'd7);
    chk("R3", "irq pc", {16'd0, pc_out}, 32'h5678);
    chk("R3", "irq p", {24'd0, p_out}, 32'h05);
    chk("R3", "irq sp", {24'd0, sp_out}, 32'hFC);
    chk("R3", "irq pushed PCH", {24'd0, mem[midx(16'h01FF)]}, 32'h80);
    chk("R3", "irq pushed PCL", {24'd0, mem[midx(16'h01FE)]}, 32'h20);
    chk("R3", "irq pushed P, B clear", {24'd0, mem[midx(16'h01FD)]}, 32'h01);

    // R4 NMI taken with I set, one extra edge for detection
    @(negedge clk);
    p_in = 8'h04; pc_in = 16'h8030; nmi_req = 1'b1;
    @(posedge clk);
    #1;
    wait_done(n);
    chk("R4", "nmi edges to done", n, 32'd8);
    chk("R4", "nmi cycles port", {29'd0, cycles}, 32'd7);
    chk("R4", "nmi pc", {16'd0, pc_out}, 32'h9000);
    chk("R4", "nmi p", {24'd0, p_out}, 32'h04);
    chk("R4", "nmi sp", {24'd0, sp_out}, 32'hF9);
    chk("R4", "nmi pushed PCL", {24'd0, mem[midx(16'h01FB)]}, 32'h30);
    chk("R4", "nmi pushed P, B clear", {24'd0, mem[midx(16'h01FA)]}, 32'h04);
    nmi_req = 1'b0;

    // R5 reset sequence
    @(negedge clk);
    w0 = wr_cnt; p_in = 8'h00; pc_in = 16'h8040; rst_req = 1'b1;
    @(posedge clk);
    #1 rst_req = 1'b0;
    wait_done(n);
    chk("R5", "reset cycles", n, 32'd7);
    chk("R5", "reset pc", {16'd0, pc_out}, 32'h1234);
    chk("R5", "reset p", {24'd0, p_out}, 32'h04);
    chk("R5", "reset sp", {24'd0, sp_out}, 32'hF9);
    chk("R5", "reset writes", wr_cnt - w0, 32'd0);

    // R12 reset beats IRQ and a request
    @(negedge clk);
    w0 = wr_cnt; p_in = 8'h00; req_op = 3'd4; req_valid = 1'b1;
    irq_req = 1'b1; rst_req = 1'b1;
    #1 chk("R12", "ready with reset pending", {31'd0, req_ready}, 32'd0);
    @(posedge clk);
    #1 begin rst_req = 1'b0; irq_req = 1'b0; req_valid = 1'b0; end
    wait_done(n);
    chk("R12", "reset won, pc", {16'd0, pc_out}, 32'h1234);
    chk("R12", "reset won, writes", wr_cnt - w0, 32'd0);

    // R12 NMI beats IRQ
    @(negedge clk);
    p_in = 8'h00; pc_in = 16'h8050; nmi_req = 1'b1;
    @(posedge clk);
    #1 irq_req = 1'b1;
    @(posedge clk);
    #1 irq_req = 1'b0;
    wait_done(n);
    chk("R12", "nmi won, pc", {16'd0, pc_out}, 32'h9000);
    chk("R12", "nmi won, cycles", n, 32'd7);
    nmi_req = 1'b0;

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule